// File: doc/BRIEF.md
# I2C Serial Memory Slave Front End

This block is the bus-facing half of a small byte-addressed serial memory. It watches an I2C bus through two inputs (SCL and the SDA level) and answers through a single open-drain control, `sda_pull_o`, which pulls SDA low when it is 1. Both bus lines are resynchronised to the system clock. Start and stop conditions are found from their edges, and every bus bit is taken on a synchronised SCL rising edge.

After a start, the block checks the first byte against its own bus address. That address is a fixed four-bit type code, a zero bit, and two bits read from strap inputs. A write-mode transfer carries a 12-bit word address in two bytes, and that value goes into an internal address counter. If a stop follows the address, no access takes place. If a repeated start follows, the master can read from the new address at once. A read-mode transfer returns bytes from the counter's address. The counter steps after every byte, wraps at the top of the array, and the read goes on for as long as the master acknowledges.

The storage is a read-only array of 4096 bytes. Its contents follow a fixed pattern of the address, so reads give known values and no storage flops are needed.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset the block keeps SDA released, and it acknowledges no byte until a start condition has been seen.
- R2: The first byte after a start is acknowledged (SDA held low for the whole ninth clock) only if its bits, MSB first, are 1,0,1,0, then 0, then `dev_sel_i[1]`, `dev_sel_i[0]`, then R/W. On any mismatch the block stays silent until the next start.
- R3: With R/W = 0, the next two bytes are each acknowledged. The word address is the low 4 bits of the first byte (upper 4 ignored) followed by the second byte.
- R4: An address load that ends in a stop performs no access and leaves the counter equal to the loaded word address.
- R5: A read (R/W = 1) returns the byte at the counter's address, MSB first, and the counter advances by one for each byte sent.
- R6: An address load followed by a repeated start and a read returns the byte at the loaded address.
- R7: When the master acknowledges a data byte, the byte at the next address follows. When it does not, the transfer ends and the counter points one past the last byte sent.
- R8: The counter wraps from address 0xFFF to 0x000 during reads.
- R9: The byte stored at address a is a[7:0] XOR {a[11:8], a[11:8]}.
- R10: After a stop the block ignores all bus bits, drives nothing, and leaves the counter unchanged until the next start.
- R11: During the master's acknowledge slot after a data byte, the block releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level as seen on the wire |
| dev_sel_i | input | 2 | Strap bits for the two low address bits of the bus address |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |

## Verification
Two events can fall on the same system-clock edge: the load of the next byte in a sequential read, and the counter stepping across the top of the array. The bench loads the address 0xFFE with a stop, then runs a four-byte acknowledged read. It requires the bytes of 0xFFE, 0xFFF, 0x000 and 0x001 in that order, and a following current-address read must return the byte at 0x002. A second overlap is a stop that arrives while the block is idle after a read. Bytes clocked after that stop must draw no acknowledge and must not move the counter.

// File: rtl/i2cm_pkg.sv
// Package: shared types and constants for the serial memory slave.
// Assumes: bytes are 8 bits, sent MSB first.
package i2cm_pkg;

    // Controller states; receive states are followed by an acknowledge state.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_HOLD,
        ST_TX,
        ST_TX_ACK
    } st_t;

    localparam logic [3:0] DEV_TYPE = 4'b1010;
    localparam int         BYTE_W   = 8;

endpackage

// File: rtl/i2cm_bus_sync.sv
// Module: i2cm_bus_sync
// Brings SCL and SDA into the clk domain through a SYNC_LEN-stage chain.
// Reports SCL edges and start/stop conditions as one-cycle pulses.
// Assumes: the bus is much slower than clk; both lines idle high.
module i2cm_bus_sync #(
    parameter int SYNC_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_lvl,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_LEN-1:0] scl_pipe, sda_pipe;
    logic                scl_q, sda_q;
    logic                scl_s, sda_s;

    assign scl_s = scl_pipe[SYNC_LEN-1];
    assign sda_s = sda_pipe[SYNC_LEN-1];

    // Synchronizer chains plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_LEN-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_LEN-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    // Edge and condition decode: SDA moving while SCL stays high.
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        sda_lvl   = sda_s;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end

    // A start and a stop can never be reported together.
    assert_start_stop_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_det && stop_det));

endmodule

// File: rtl/i2cm_pattern_rom.sv
// Module: i2cm_pattern_rom
// Read-only byte array whose contents are a fixed function of the address:
// bit i = addr[i] XOR addr[8 + i mod HI_W].
// Assumes: 8 < ADDR_W <= 16; the read is purely combinational.
module i2cm_pattern_rom #(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [7:0]        data_o
);

    localparam int HI_W = ADDR_W - 8;

    // One XOR per data bit, folding the upper address bits over the byte.
    for (genvar i = 0; i < 8; i++) begin : g_bit
        assign data_o[i] = addr_i[i] ^ addr_i[8 + (i % HI_W)];
    end

endmodule

// File: rtl/i2c_mem_slave.sv
// Module: i2c_mem_slave
// I2C slave front end for a byte-addressed read-only serial memory.
// Decodes the bus address, loads a word address on writes, and serves
// current, random and sequential reads from an auto-incrementing counter.
// Assumes: SDA changes only while SCL is low, except at start/stop.
module i2c_mem_slave #(
    parameter int ADDR_W   = 12,
    parameter int SYNC_LEN = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] dev_sel_i,
    output logic       sda_pull_o
);
    import i2cm_pkg::*;

    localparam int HI_W = ADDR_W - BYTE_W;

    logic              scl_rise, scl_fall, sda_lvl, start_det, stop_det;
    st_t               state;
    logic [2:0]        bit_cnt;
    logic [7:0]        sh_rx, sh_tx, rx_next, rd_data;
    logic [ADDR_W-1:0] addr_cnt;
    logic [HI_W-1:0]   addr_hi;
    logic              ack_phase, m_ack, rw, pull;
    logic              dev_match, bus_evt, load_now;

    i2cm_bus_sync #(.SYNC_LEN(SYNC_LEN)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_lvl   (sda_lvl),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cm_pattern_rom #(.ADDR_W(ADDR_W)) u_rom (
        .addr_i (addr_cnt),
        .data_o (rd_data)
    );

    // Receive shift value, address compare, and the next-byte load strobe.
    always_comb begin
        rx_next   = {sh_rx[6:0], sda_lvl};
        dev_match = (rx_next[7:1] == {DEV_TYPE, 1'b0, dev_sel_i});
        bus_evt   = start_det | stop_det;
        load_now  = scl_fall && !bus_evt &&
                    ((state == ST_DEV_ACK && ack_phase && rw) ||
                     (state == ST_TX_ACK && m_ack));
    end

    // Main controller: bus conditions first, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            sh_rx     <= '0;
            sh_tx     <= '0;
            addr_cnt  <= '0;
            addr_hi   <= '0;
            ack_phase <= 1'b0;
            m_ack     <= 1'b0;
            rw        <= 1'b0;
            pull      <= 1'b0;
        end else if (start_det) begin
            state     <= ST_DEV;
            bit_cnt   <= '0;
            ack_phase <= 1'b0;
            pull      <= 1'b0;
        end else if (stop_det) begin
            state     <= ST_IDLE;
            ack_phase <= 1'b0;
            pull      <= 1'b0;
        end else if (load_now) begin
            sh_tx    <= rd_data;
            pull     <= ~rd_data[7];
            addr_cnt <= addr_cnt + 1'b1;
            bit_cnt  <= '0;
            ack_phase <= 1'b0;
            state    <= ST_TX;
        end else begin
            case (state)
                ST_DEV, ST_AHI, ST_ALO: begin
                    if (scl_rise) begin
                        sh_rx   <= rx_next;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == 3'd7) begin
                            if (state == ST_DEV) begin
                                rw    <= rx_next[0];
                                state <= dev_match ? ST_DEV_ACK : ST_IDLE;
                            end else if (state == ST_AHI) begin
                                addr_hi <= rx_next[HI_W-1:0];
                                state   <= ST_AHI_ACK;
                            end else begin
                                state <= ST_ALO_ACK;
                            end
                        end
                    end
                end
                ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK: begin
                    if (scl_fall) begin
                        if (!ack_phase) begin
                            ack_phase <= 1'b1;
                            pull      <= 1'b1;
                        end else begin
                            ack_phase <= 1'b0;
                            pull      <= 1'b0;
                            bit_cnt   <= '0;
                            if (state == ST_DEV_ACK) begin
                                state <= ST_AHI;
                            end else if (state == ST_AHI_ACK) begin
                                state <= ST_ALO;
                            end else begin
                                addr_cnt <= {addr_hi, sh_rx};
                                state    <= ST_HOLD;
                            end
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bit_cnt == 3'd7) begin
                            pull  <= 1'b0;
                            m_ack <= 1'b0;
                            state <= ST_TX_ACK;
                        end else begin
                            sh_tx   <= {sh_tx[6:0], 1'b0};
                            pull    <= ~sh_tx[6];
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        m_ack <= ~sda_lvl;
                    end
                    if (scl_fall) begin
                        state <= ST_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_pull_o = pull;

    // Reset leaves the data line released.
    assert_reset_release_R1: assert property (@(posedge clk)
        !rst_n |=> !sda_pull_o);

    // The address acknowledge is only given for this device's bus address.
    assert_dev_ack_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV_ACK) |-> (sh_rx[7:4] == DEV_TYPE && sh_rx[3:1] == {1'b0, dev_sel_i}));

    // Every byte fetched advances the counter by exactly one.
    assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_now |=> addr_cnt == ADDR_W'($past(addr_cnt) + 1'b1));

    // The top address is followed by address zero.
    assert_cnt_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_now && addr_cnt == '1) |=> addr_cnt == '0);

    // A stop always releases the line.
    assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull_o);

    // The master's acknowledge slot is never driven by the slave.
    assert_mack_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX_ACK) |-> !sda_pull_o);

endmodule

// File: tb/i2c_mem_slave_test.sv
// Directed bench: one task per scenario, each checking its own results.
module i2c_mem_slave_test;

    localparam int Q = 10;  // system clocks per quarter bus bit

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [1:0] dev_sel = 2'b10;
    logic       sda_pull;
    logic       sda_line;
    int         n_chk = 0;
    int         n_bad = 0;

    localparam logic [7:0] DEV_W = 8'hA4;  // 1010_0_10_0
    localparam logic [7:0] DEV_R = 8'hA5;

    assign sda_line = m_sda & ~sda_pull;

    always #4 clk = ~clk;  // 125 MHz

    i2c_mem_slave uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .dev_sel_i  (dev_sel),
        .sda_pull_o (sda_pull)
    );

    function automatic logic [7:0] pat(input logic [11:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_q();
        scl = 1'b1;   wait_q();
        m_sda = 1'b0; wait_q();
        scl = 1'b0;   wait_q();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_q();
        scl = 1'b1;   wait_q();
        m_sda = 1'b1; wait_q();
    endtask

    task automatic bit_clk(input logic b, output logic r);
        m_sda = b;  wait_q();
        scl = 1'b1; wait_q();
        r = sda_line; wait_q();
        scl = 1'b0; wait_q();
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bit_clk(b[i], r);
        bit_clk(1'b1, r);
        ack = ~r;
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] d, output logic slot);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bit_clk(1'b1, r);
            d[i] = r;
        end
        bit_clk(~mack, slot);
    endtask

    task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, input string req);
        logic a;
        bus_start();
        wr_byte(DEV_W, a); chk(req, a, 1);
        wr_byte(hi, a);    chk("R3", a, 1);
        wr_byte(lo, a);    chk("R3", a, 1);
        bus_stop();
    endtask

    task automatic cur_read(input logic [11:0] exp_a, input string req);
        logic a, s;
        logic [7:0] d;
        bus_start();
        wr_byte(DEV_R, a); chk(req, a, 1);
        rd_byte(1'b0, d, s);
        chk(req, d, pat(exp_a));
        chk("R11", s, 1);
        bus_stop();
    endtask

    task automatic t_reset();
        logic a;
        chk("R1", sda_pull, 0);
        scl = 1'b0; wait_q();
        wr_byte(DEV_W, a); chk("R1", a, 0);
        scl = 1'b1; wait_q();
        m_sda = 1'b1; wait_q();
    endtask

    task automatic t_mismatch();
        logic a;
        bus_start(); wr_byte(8'hA0, a); chk("R2", a, 0);
        wr_byte(8'h00, a); chk("R2", a, 0);
        bus_start(); wr_byte(8'hAC, a); chk("R2", a, 0);
        bus_start(); wr_byte(8'hB4, a); chk("R2", a, 0);
        bus_stop();
    endtask

    task automatic t_set_addr();
        set_addr(8'h12, 8'h34, "R4");
        cur_read(12'h234, "R4");
        set_addr(8'hF2, 8'h34, "R3");
        cur_read(12'h234, "R3");
    endtask

    task automatic t_current();
        cur_read(12'h235, "R5");
        cur_read(12'h236, "R5");
    endtask

    task automatic t_random();
        logic a, s;
        logic [7:0] d;
        bus_start();
        wr_byte(DEV_W, a); chk("R6", a, 1);
        wr_byte(8'h07, a); chk("R3", a, 1);
        wr_byte(8'hAB, a); chk("R3", a, 1);
        bus_start();
        wr_byte(DEV_R, a); chk("R6", a, 1);
        rd_byte(1'b1, d, s); chk("R6", d, pat(12'h7AB));
        rd_byte(1'b0, d, s); chk("R7", d, pat(12'h7AC));
        chk("R11", s, 1);
        bus_stop();
        cur_read(12'h7AD, "R7");
    endtask

    task automatic t_wrap();
        logic a, s;
        logic [7:0] d;
        set_addr(8'h0F, 8'hFE, "R8");
        bus_start();
        wr_byte(DEV_R, a); chk("R8", a, 1);
        rd_byte(1'b1, d, s); chk("R8", d, pat(12'hFFE));
        rd_byte(1'b1, d, s); chk("R8", d, pat(12'hFFF));
        rd_byte(1'b1, d, s); chk("R8", d, pat(12'h000));
        rd_byte(1'b0, d, s); chk("R8", d, pat(12'h001));
        bus_stop();
    endtask

    task automatic t_ignore();
        logic a;
        scl = 1'b0; wait_q();
        wr_byte(DEV_W, a); chk("R10", a, 0);
        wr_byte(8'h05, a); chk("R10", a, 0);
        wr_byte(DEV_R, a); chk("R10", a, 0);
        scl = 1'b1; wait_q();
        m_sda = 1'b1; wait_q();
        cur_read(12'h002, "R10");
    endtask

    task automatic t_content();
        set_addr(8'h0C, 8'h3F, "R9");
        cur_read(12'hC3F, "R9");
        chk("R9", pat(12'hC3F), 8'hF3);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_mismatch();
        t_set_addr();
        t_current();
        t_random();
        t_wrap();
        t_ignore();
        t_content();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule